// File: doc/BRIEF.md
# Mixed-Sign Vector Dot-Product Accumulator

This datapath sits beside a processor core and speeds up 8-bit matrix products. Each command carries one vector of eight unsigned 8-bit activations and a weight operand holding two rows of eight signed 8-bit values. For each row, the block forms the dot product of that row with the activation vector. It then adds the two results into two private signed 32-bit accumulators. A run of zeroing and plain accumulate commands builds up one pair of output elements of a matrix product. A store command then reads that pair out. The accumulators can be read only through the store command.

Commands arrive on a valid/ready port with a 2-bit opcode. The controller is a two-state machine:

- **ST_IDLE**: the port is ready. In this state a store or no-op is carried out at once.
- **ST_CALC**: entered on the transition *ACCEPT_MAC*, taken when a zeroing or plain accumulate command is accepted in ST_IDLE. The port is not ready in this state. The dot products are formed from registered operands, and the accumulators are written at the end of the cycle.
- *FINISH*: the transition from ST_CALC back to ST_IDLE, taken after one cycle in ST_CALC.

A multiply-accumulate therefore occupies two clock cycles. A store returns its 64-bit result one cycle after it is accepted, together with a one-cycle valid pulse.

Top module: `vdot_acc_top`

## Requirements
- R1: After the synchronous reset `rst`, both accumulators are zero, `cmd_ready` is high and `res_valid` is low; a store issued right after reset returns 64'h0.
- R2: Element j of `act_bus` and of each weight row sits at bits [8j+7:8j]; row 0 (feeding accumulator 0) is `wgt_bus[63:0]` and row 1 (feeding accumulator 1) is `wgt_bus[127:64]`.
- R3: Activations are taken as unsigned and weights as two's-complement signed; each product is sign-extended before summing (eight products of 255 and -128 sum to -261120).
- R4: Opcode 2'b01 (zeroing accumulate) sets each accumulator to exactly its new dot product, discarding the old value.
- R5: Opcode 2'b10 (plain accumulate) adds each new dot product to the accumulator's current value.
- R6: Accumulation wraps modulo 2^32 with no saturation.
- R7: A multiply-accumulate is accepted only when `cmd_ready` is high; `cmd_ready` is low for exactly the one cycle after acceptance and returns high with the accumulators updated.
- R8: Opcode 2'b11 (store) raises `res_valid` for one cycle, one cycle after acceptance, with `res_data[31:0]` = accumulator 0 and `res_data[63:32]` = accumulator 1; a store leaves the accumulators unchanged.
- R9: A store accepted in the first cycle after a multiply-accumulate completes returns the updated accumulator values.
- R10: Opcode 2'b00 is accepted as a no-op: it produces no result pulse and leaves the accumulators unchanged.
- R11: A command held on the port while `cmd_ready` is low is not taken; it is carried out exactly once, after `cmd_ready` returns high.
- R12: `res_data` holds its last stored value in every cycle in which `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_op | input | 2 | 00 no-op, 01 zeroing accumulate, 10 accumulate, 11 store |
| act_bus | input | 64 | Eight unsigned activations |
| wgt_bus | input | 128 | Two rows of eight signed weights |
| res_valid | output | 1 | One-cycle pulse marking a store result |
| res_data | output | 64 | Accumulator 1 in the upper word, accumulator 0 in the lower word |

## Verification
The bench drives extreme operands (255 against -128 and 127) that expose a design which zero-extends the weights or truncates the products. Such a design returns a large positive sum where a negative one is due. One-hot weight rows locate every byte. A design that swaps the rows or reverses the elements puts the result in the wrong word or picks up the wrong activation. A store is queued right behind an accumulate while the port is busy. A design that reads the accumulators one cycle early returns stale data, and one that takes a command while busy runs it twice. A long chain of accumulates drives the sums past 2^31. A saturating design sticks at the maximum where the correct one wraps negative.

// File: rtl/vdot_pkg.sv
package vdot_pkg;
    localparam int VD_ELEMS = 8;
    localparam int VD_EW    = 8;
    localparam int VD_LANES = 2;
    localparam int VD_ACCW  = 32;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_MACZ  = 2'b01,
        OP_MACC  = 2'b10,
        OP_STORE = 2'b11
    } vdot_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CALC = 1'b1
    } vdot_state_e;
endpackage

// File: rtl/vdot_lane.sv
module vdot_lane
    import vdot_pkg::*;
#(
    parameter int ELEMS = VD_ELEMS,
    parameter int EW    = VD_EW,
    parameter int ACCW  = VD_ACCW
) (
    input  logic [ELEMS*EW-1:0] act,
    input  logic [ELEMS*EW-1:0] wgt,
    output logic [ACCW-1:0]     dot
);
    localparam int PW = 2*EW + 1;

    logic signed [PW-1:0] prod [ELEMS];

    for (genvar g = 0; g < ELEMS; g++) begin : g_mul
        logic signed [EW:0]   a_s;
        logic signed [EW-1:0] w_s;
        assign a_s = $signed({1'b0, act[g*EW +: EW]});
        assign w_s = $signed(wgt[g*EW +: EW]);
        assign prod[g] = PW'(a_s * w_s);
    end

    always_comb begin
        dot = '0;
        for (int i = 0; i < ELEMS; i++) begin
            dot = dot + {{(ACCW-PW){prod[i][PW-1]}}, prod[i]};
        end
    end
endmodule

// File: rtl/vdot_ctrl.sv
module vdot_ctrl
    import vdot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic       cmd_ready,
    output logic       mac_take,
    output logic       store_take,
    output logic       calc_en
);
    vdot_state_e state_q, state_d;
    logic        accept;

    assign accept = cmd_valid && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && (cmd_op == OP_MACZ || cmd_op == OP_MACC)) state_d = ST_CALC;
            ST_CALC: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_ready  = 1'b0;
        mac_take   = 1'b0;
        store_take = 1'b0;
        calc_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready  = 1'b1;
                mac_take   = accept && (cmd_op == OP_MACZ || cmd_op == OP_MACC);
                store_take = accept && (cmd_op == OP_STORE);
            end
            ST_CALC: calc_en = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/vdot_acc_top.sv
module vdot_acc_top
    import vdot_pkg::*;
#(
    parameter int ELEMS = VD_ELEMS,
    parameter int EW    = VD_EW,
    parameter int LANES = VD_LANES,
    parameter int ACCW  = VD_ACCW
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cmd_valid,
    output logic                         cmd_ready,
    input  logic [1:0]                   cmd_op,
    input  logic [ELEMS*EW-1:0]          act_bus,
    input  logic [LANES*ELEMS*EW-1:0]    wgt_bus,
    output logic                         res_valid,
    output logic [LANES*ACCW-1:0]        res_data
);
    localparam int ROWW = ELEMS*EW;

    logic             mac_take, store_take, calc_en;
    logic [ROWW-1:0]  act_q;
    logic [LANES*ROWW-1:0] wgt_q;
    logic             zero_q;
    logic [ACCW-1:0]  acc  [LANES];
    logic [ACCW-1:0]  dot  [LANES];
    logic [LANES*ACCW-1:0] acc_flat;

    vdot_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_ready  (cmd_ready),
        .mac_take   (mac_take),
        .store_take (store_take),
        .calc_en    (calc_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            wgt_q  <= '0;
            zero_q <= 1'b0;
        end else if (mac_take) begin
            act_q  <= act_bus;
            wgt_q  <= wgt_bus;
            zero_q <= (cmd_op == OP_MACZ);
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vdot_lane #(.ELEMS(ELEMS), .EW(EW), .ACCW(ACCW)) u_lane (
            .act (act_q),
            .wgt (wgt_q[l*ROWW +: ROWW]),
            .dot (dot[l])
        );

        always_ff @(posedge clk) begin
            if (rst)          acc[l] <= '0;
            else if (calc_en) acc[l] <= (zero_q ? '0 : acc[l]) + dot[l];
        end

        assign acc_flat[l*ACCW +: ACCW] = acc[l];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= store_take;
            if (store_take) res_data <= acc_flat;
        end
    end
endmodule

// File: rtl/vdot_acc_chk.sv
module vdot_acc_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         cmd_valid,
    input logic         cmd_ready,
    input logic [1:0]   cmd_op,
    input logic         res_valid,
    input logic [W-1:0] res_data,
    input logic [W-1:0] acc_flat
);
    logic take_mac, take_st;
    assign take_mac = cmd_valid && cmd_ready && (cmd_op == 2'b01 || cmd_op == 2'b10);
    assign take_st  = cmd_valid && cmd_ready && (cmd_op == 2'b11);

    p_busy_after_mac_r7: assert property (@(posedge clk) disable iff (rst)
        take_mac |=> !cmd_ready);
    p_busy_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |=> cmd_ready);
    p_store_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        take_st |=> res_valid);
    p_pulse_cause_r8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(take_st));
    p_hold_data_r12: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(res_data));
    p_acc_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_ready) |-> $stable(acc_flat));
endmodule

bind vdot_acc_top vdot_acc_chk #(.W(LANES*ACCW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .res_valid (res_valid),
    .res_data  (res_data),
    .acc_flat  (acc_flat)
);

// File: tb/tb_vdot_acc_top.sv
module tb_vdot_acc_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [1:0]   cmd_op = 2'b00;
    logic [63:0]  act_bus = '0;
    logic [127:0] wgt_bus = '0;
    logic         res_valid;
    logic [63:0]  res_data;

    always #2.5 clk = ~clk;

    vdot_acc_top dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .act_bus(act_bus), .wgt_bus(wgt_bus),
        .res_valid(res_valid), .res_data(res_data)
    );

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference
    int          m_acc0, m_acc1;
    bit          m_busy, m_rv, m_zero;
    logic [63:0] m_rd, m_act;
    logic [127:0] m_wgt;

    function automatic int dotp(logic [63:0] a, logic [63:0] w);
        int s = 0;
        for (int j = 0; j < 8; j++) begin
            int av = {24'b0, a[j*8 +: 8]};
            int wv = {{24{w[j*8+7]}}, w[j*8 +: 8]};
            s += av * wv;
        end
        return s;
    endfunction

    task automatic model_step();
        if (rst) begin
            m_acc0 = 0; m_acc1 = 0; m_busy = 0; m_rv = 0; m_rd = '0;
        end else begin
            m_rv = 0;
            if (m_busy) begin
                m_acc0 = (m_zero ? 0 : m_acc0) + dotp(m_act, m_wgt[63:0]);
                m_acc1 = (m_zero ? 0 : m_acc1) + dotp(m_act, m_wgt[127:64]);
                m_busy = 0;
            end else if (cmd_valid) begin
                if (cmd_op == 2'b01 || cmd_op == 2'b10) begin
                    m_busy = 1; m_zero = (cmd_op == 2'b01);
                    m_act = act_bus; m_wgt = wgt_bus;
                end else if (cmd_op == 2'b11) begin
                    m_rv = 1; m_rd = {m_acc1, m_acc0};
                end
            end
        end
    endtask

    task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic compare();
        chk({tag, " R7 R11 ready"}, {63'b0, cmd_ready}, {63'b0, !m_busy});
        chk({tag, " R8 res_valid"}, {63'b0, res_valid}, {63'b0, m_rv});
        chk({tag, " R12 res_data"}, res_data, m_rd);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic issue(logic [1:0] op, logic [63:0] a, logic [127:0] w);
        cmd_valid = 1; cmd_op = op; act_bus = a; wgt_bus = w;
        while (!cmd_ready) cycle();
        cycle();
        cmd_valid = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic store_expect(string t, logic [63:0] exp);
        issue(2'b11, '0, '0);
        chk(t, res_data, exp);
        chk({t, " pulse"}, {63'b0, res_valid}, 64'd1);
        cycle();
    endtask

    initial begin
        repeat (3) cycle();
        @(negedge clk); rst = 0;
        cycle();
        tag = "R1";
        chk("R1 reset ready", {63'b0, cmd_ready}, 64'd1);
        chk("R1 reset res_valid", {63'b0, res_valid}, 64'd0);
        store_expect("R1 store after reset", 64'h0);

        tag = "R2";
        issue(2'b01, 64'h0807060504030201, {64'hFF00000000000000, 64'h0000000000010000});
        cycle();
        store_expect("R2 byte placement", {32'hFFFFFFF8, 32'h00000003});

        tag = "R5";
        issue(2'b10, 64'h0807060504030201, {64'hFF00000000000000, 64'h0000000000010000});
        cycle();
        store_expect("R5 accumulate", {32'hFFFFFFF0, 32'h00000006});

        tag = "R10";
        issue(2'b00, 64'hFFFFFFFFFFFFFFFF, {128{1'b1}});
        chk("R10 no pulse", {63'b0, res_valid}, 64'd0);
        cycle();
        store_expect("R10 nop unchanged", {32'hFFFFFFF0, 32'h00000006});

        tag = "R3_R4_R9_R11";
        cmd_valid = 1; cmd_op = 2'b01; act_bus = {8{8'hFF}};
        wgt_bus = {{8{8'h7F}}, {8{8'h80}}};
        cycle();
        cmd_op = 2'b11;
        cycle();
        chk("R11 store held while busy", {63'b0, res_valid}, 64'd0);
        cycle();
        cmd_valid = 0;
        chk("R3 R4 R9 signed products", res_data, {32'h0003F408, 32'hFFFC0400});
        cycle();
        chk("R11 store ran once", {63'b0, res_valid}, 64'd0);

        tag = "R6";
        issue(2'b01, {8{8'hFF}}, {{8{8'h7F}}, {8{8'h7F}}});
        for (int k = 0; k < 8400; k++) issue(2'b10, {8{8'hFF}}, {{8{8'h7F}}, {8{8'h7F}}});
        cycle();
        begin
            longint tot = 64'(8401) * 64'(259080);
            logic [31:0] w32 = tot[31:0];
            store_expect("R6 wrap", {w32, w32});
            chk("R6 sign bit after wrap", {63'b0, res_data[31]}, 64'd1);
        end

        tag = "random";
        for (int k = 0; k < 3000; k++) begin
            cmd_valid = 1'($urandom_range(0, 1));
            cmd_op    = 2'($urandom_range(0, 3));
            act_bus   = {$urandom, $urandom};
            wgt_bus   = {$urandom, $urandom, $urandom, $urandom};
            cycle();
        end
        cmd_valid = 0;
        cycle(); cycle();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule